// File: doc/BRIEF.md
# Receive-Side Cell Port Arbiter with Per-Port Ready Lines

This block sits on the cell-layer side of an 8-bit cell bus that carries 53-byte cells from four physical-layer ports. Each port has its own cell-ready line, so the block never polls addresses. It watches all four ready lines every cycle. It picks a port, drives that port's address and then an active-low read enable, and counts the requested bytes of each cell. Every byte that comes back is passed to a downstream sink with a valid strobe and the start-of-cell flag, and the flag's position is checked.

At each cell boundary the block makes one decision. If another port is waiting, it releases the enable and moves to that port on the same edge. If no other port is waiting but the current port still reports a cell, it holds the enable low so the next cell follows with no gap. If no port is waiting, it releases the enable and goes back to watching. When several ports are waiting, they are served in rotating order.

Top module: `utx_rx_ctrl`

## Requirements
- R1: A synchronous active-low reset sets `rx_enb_n` high, `rx_addr` to all ones (the idle don't-care value), `out_valid` and `soc_err` low, and the rotation so that port 1 wins the first tie.
- R2: In idle, on the first rising edge where any `cell_avail` bit is high, `rx_addr` takes the winning port's number (port p on bit p-1 gets address p) while `rx_enb_n` stays high for that cycle.
- R3: On the following edge `rx_enb_n` goes low with the address unchanged.
- R4: A byte is on `rx_data`/`rx_soc` in the cycle after each cycle with `rx_enb_n` low. It appears on `out_data` with `out_valid` one edge later, so the first byte of a transfer shows up two cycles after the enable first goes low.
- R5: For each cell, the enable is held low for exactly 53 consecutive cycles. It is released only at a cell boundary.
- R6: At a cell boundary, if another port's ready line is high, `rx_enb_n` goes high and `rx_addr` changes to that port on the same edge. The enable goes low again one cycle later.
- R7: At a cell boundary with no other port waiting and the current port's line high, `rx_enb_n` stays low and the next cell follows with no gap. Its start-of-cell flag comes 53 bytes after the previous one.
- R8: At a cell boundary with no port waiting, `rx_enb_n` goes high, `rx_addr` returns to all ones, and both stay there while no line is high.
- R9: When several ports are waiting at a decision, the winner is the first waiting port after the most recently served one, in the order 1,2,3,4,1.
- R10: `out_soc` forwards the sampled flag. `soc_err` pulses with the byte when the flag is missing at cell position 0 or present at any other position (positions 0 to 52).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_avail | input | NPORTS | Per-port cell-ready lines, bit p-1 for port p |
| rx_data | input | DATA_W | Byte from the selected port |
| rx_soc | input | 1 | Start-of-cell flag from the selected port |
| rx_addr | output | ADDR_W | Port address; all ones when no port is selected |
| rx_enb_n | output | 1 | Read enable, active low |
| out_valid | output | 1 | Strobe for a forwarded byte |
| out_data | output | DATA_W | Forwarded byte |
| out_soc | output | 1 | Forwarded start-of-cell flag |
| soc_err | output | 1 | Pulse on a misplaced or missing start-of-cell flag |

## Verification
Several ready-line patterns are applied. A one-cycle pulse on a single port checks the basic grant, enable and byte timing. A line that stays up and then drops mid-cell separates the back-to-back case from the return to idle. Two ports held together check the handover at each boundary. All four ports held together, and a set of ports that arrives while port 3 is being served, show whether the rotation starts after the last-served port or at a fixed priority. Runs with the start-of-cell flag removed at position 0 or moved to position 17 check the error pulse at both kinds of misplacement, and a reset in the middle of a cell checks the return to the reset state.

// File: rtl/utx_pkg.sv
package utx_pkg;
    // Controller phases: watching lines, address presented, reading cells
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_XFER   = 2'd2
    } utx_state_e;
endpackage

// File: rtl/utx_rr_pick.sv
// Rotating picker: returns the first set request bit after index `last`,
// wrapping around; `last` itself has the lowest priority.
// Assumes NPORTS >= 2. Purely combinational.
module utx_rr_pick #(
    parameter int NPORTS = 4,
    parameter int IW     = $clog2(NPORTS)
) (
    input  logic [NPORTS-1:0] req,
    input  logic [IW-1:0]     last,
    output logic              found,
    output logic [IW-1:0]     pick
);
    // Scan from farthest to nearest so the nearest waiting port wins
    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int k = NPORTS; k >= 1; k--) begin
            int c;
            c = (int'(last) + k) % NPORTS;
            if (req[c]) begin
                found = 1'b1;
                pick  = IW'(c);
            end
        end
    end
endmodule

// File: rtl/utx_cell_rx.sv
// Receive byte tracker: a byte is on the bus the cycle after a request
// cycle. It captures the byte, forwards it registered, keeps the cell
// position and flags a misplaced start-of-cell marker.
// Assumes cells are CELL_BYTES long and requests come in whole cells.
module utx_cell_rx #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_now,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_soc,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_soc,
    output logic              soc_err
);
    localparam int CW       = $clog2(CELL_BYTES);
    localparam int LAST_POS = CELL_BYTES - 1;

    logic          live;
    logic [CW-1:0] pos;

    // Mark the cycle in which the port drives a requested byte
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= req_now;
    end

    // Capture, forward and check each arriving byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_soc   <= 1'b0;
            soc_err   <= 1'b0;
            pos       <= '0;
        end else begin
            out_valid <= live;
            soc_err   <= 1'b0;
            if (live) begin
                out_data <= rx_data;
                out_soc  <= rx_soc;
                soc_err  <= rx_soc != (pos == '0);
                pos      <= (pos == CW'(LAST_POS)) ? '0 : pos + CW'(1);
            end
        end
    end

    AST_POS_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= CW'(LAST_POS)); // R4
    AST_BYTE_AFTER_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_now, 2)); // R4
    AST_ERR_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        soc_err |-> out_valid); // R10
endmodule

// File: rtl/utx_rx_ctrl.sv
// Receive-side cell controller for NPORTS ports, each with its own
// cell-ready line. It grants a port, presents the address, then holds the
// active-low enable for whole cells. At each cell boundary it hands over,
// continues, or goes idle. Assumes ports latch the address one edge
// after it is driven and answer a request edge with a byte in the next cycle.
module utx_rx_ctrl #(
    parameter int NPORTS     = 4,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] cell_avail,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_soc,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              rx_enb_n,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_soc,
    output logic              soc_err
);
    import utx_pkg::*;

    localparam int PIW       = $clog2(NPORTS);
    localparam int CW        = $clog2(CELL_BYTES);
    localparam int LAST_POS  = CELL_BYTES - 1;
    localparam logic [ADDR_W-1:0] IDLE_ADDR = {ADDR_W{1'b1}};

    utx_state_e     state;
    logic [PIW-1:0] cur;
    logic [CW-1:0]  qcnt;
    logic [NPORTS-1:0] others;
    logic [NPORTS-1:0] pick_req;
    logic           pick_found;
    logic [PIW-1:0] pick_idx;
    logic           at_boundary;

    // Candidate set: every line when idle, all but the current port otherwise
    always_comb begin
        others   = cell_avail & ~(NPORTS'(1) << cur);
        pick_req = (state == ST_IDLE) ? cell_avail : others;
    end

    assign at_boundary = (state == ST_XFER) && (qcnt == CW'(LAST_POS));

    utx_rr_pick #(.NPORTS(NPORTS), .IW(PIW)) u_pick (
        .req   (pick_req),
        .last  (cur),
        .found (pick_found),
        .pick  (pick_idx)
    );

    // Grant, enable and per-cell request counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur      <= PIW'(NPORTS - 1);
            qcnt     <= '0;
            rx_enb_n <= 1'b1;
            rx_addr  <= IDLE_ADDR;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pick_found) begin
                        cur     <= pick_idx;
                        rx_addr <= ADDR_W'(pick_idx) + ADDR_W'(1);
                        state   <= ST_SELECT;
                    end
                end
                ST_SELECT: begin
                    rx_enb_n <= 1'b0;
                    qcnt     <= '0;
                    state    <= ST_XFER;
                end
                ST_XFER: begin
                    if (at_boundary) begin
                        if (pick_found) begin
                            cur      <= pick_idx;
                            rx_addr  <= ADDR_W'(pick_idx) + ADDR_W'(1);
                            rx_enb_n <= 1'b1;
                            state    <= ST_SELECT;
                        end else if (cell_avail[cur]) begin
                            qcnt <= '0;
                        end else begin
                            rx_enb_n <= 1'b1;
                            rx_addr  <= IDLE_ADDR;
                            state    <= ST_IDLE;
                        end
                    end else begin
                        qcnt <= qcnt + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    utx_cell_rx #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_now   (!rx_enb_n),
        .rx_data   (rx_data),
        .rx_soc    (rx_soc),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_soc   (out_soc),
        .soc_err   (soc_err)
    );

    // Previous-cycle ready lines, kept only for the grant check
    logic [NPORTS-1:0] avail_q;
    always_ff @(posedge clk) begin
        if (!rst_n) avail_q <= '0;
        else        avail_q <= cell_avail;
    end

    AST_ADDR_MOVES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_addr) |-> rx_enb_n); // R6
    AST_ENABLE_ON_HELD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_enb_n) |-> ($stable(rx_addr) && rx_addr != IDLE_ADDR)); // R3
    AST_RELEASE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_enb_n) |-> $past(qcnt) == CW'(LAST_POS)); // R5
    AST_GRANT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELECT) |-> avail_q[cur]); // R9
    AST_IDLE_ADDR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_addr == IDLE_ADDR) |-> rx_enb_n); // R8
endmodule

// File: tb/utx_rx_ctrl_tb.sv
module utx_rx_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cell_avail = 4'b0000;
    logic [7:0] rx_data = 8'h00;
    logic       rx_soc = 1'b0;
    logic [4:0] rx_addr;
    logic       rx_enb_n;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_soc;
    logic       soc_err;

    int total = 0;
    int bad = 0;
    int corrupt = -1;
    int pos = 0;

    always #4 clk = ~clk; // 125 MHz

    utx_rx_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cell_avail(cell_avail),
        .rx_data(rx_data), .rx_soc(rx_soc), .rx_addr(rx_addr),
        .rx_enb_n(rx_enb_n), .out_valid(out_valid), .out_data(out_data),
        .out_soc(out_soc), .soc_err(soc_err)
    );

    // Port model: answers each request edge with the next byte of its cell
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) pos <= 0;
            else if (!rx_enb_n) begin
                rx_data <= {rx_addr[1:0], 6'(pos)};
                rx_soc  <= (pos == 0) ^ (pos == corrupt);
                pos     <= (pos == 52) ? 0 : pos + 1;
            end
        end
    end

    // Logs of one run
    logic       enb_l  [0:511];
    logic [4:0] addr_l [0:511];
    logic [7:0] bd [0:1023];
    logic       bs [0:1023];
    logic       be [0:1023];
    int nb, fb, nlog;
    int exp_n;
    int exp_port [0:7];
    int exp_cells [0:7];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cell_avail = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic log_run(input int n, input logic [3:0] v0, input int t1,
                           input logic [3:0] v1, input int t2, input logic [3:0] v2);
        cell_avail = v0;
        nb = 0; fb = -1; nlog = n;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            enb_l[i] = rx_enb_n;
            addr_l[i] = rx_addr;
            if (out_valid) begin
                if (fb < 0) fb = i;
                bd[nb] = out_data; bs[nb] = out_soc; be[nb] = soc_err;
                nb++;
            end
            if (i == t1) cell_avail = v1;
            if (i == t2) cell_avail = v2;
        end
    endtask

    task automatic analyze(input string name);
        int ns, sum, mis_d, mis_f, first_bad, last_end, stray;
        int sst [0:15];
        int sln [0:15];
        int sad [0:15];
        ns = 0;
        for (int i = 0; i < nlog; i++) begin
            if (!enb_l[i] && (i == 0 || enb_l[i-1])) begin
                if (ns < 16) begin sst[ns] = i; sln[ns] = 0; sad[ns] = int'(addr_l[i]); end
                ns++;
            end
            if (!enb_l[i] && ns > 0 && ns <= 16) sln[ns-1]++;
        end
        chk(ns == exp_n, "R6", {name, " segment count"}, ns, exp_n);
        if (ns != exp_n || ns == 0) return;
        chk(sst[0] == 1 && enb_l[0] && int'(addr_l[0]) == exp_port[0], "R2",
            {name, " grant address one cycle before enable"}, sst[0], 1);
        chk(addr_l[sst[0]] == addr_l[0], "R3", {name, " address held as enable falls"},
            int'(addr_l[sst[0]]), int'(addr_l[0]));
        sum = 0;
        for (int s = 0; s < ns; s++) begin
            chk(sad[s] == exp_port[s], "R9", {name, " port order"}, sad[s], exp_port[s]);
            if (exp_cells[s] > 1)
                chk(sln[s] == 53 * exp_cells[s], "R7", {name, " back-to-back length"},
                    sln[s], 53 * exp_cells[s]);
            else
                chk(sln[s] == 53, "R5", {name, " cell enable length"}, sln[s], 53);
            if (s > 0)
                chk(sst[s] == sst[s-1] + sln[s-1] + 1 && int'(addr_l[sst[s]-1]) == sad[s],
                    "R6", {name, " handover gap and address"}, sst[s], sst[s-1] + sln[s-1] + 1);
            sum += sln[s];
        end
        last_end = sst[ns-1] + sln[ns-1];
        stray = 0;
        for (int i = last_end; i < nlog; i++)
            if (!enb_l[i] || addr_l[i] != 5'h1F) stray++;
        chk(stray == 0, "R8", {name, " idle after last cell"}, stray, 0);
        chk(nb == sum && fb == sst[0] + 2, "R4", {name, " byte count / first byte"}, nb, sum);
        mis_d = 0; mis_f = 0; first_bad = -1;
        if (nb == sum) begin
            int j;
            j = 0;
            for (int s = 0; s < ns; s++)
                for (int k = 0; k < sln[s]; k++) begin
                    int p;
                    logic [7:0] ed;
                    p = k % 53;
                    ed = {2'(exp_port[s]), 6'(p)};
                    if (bd[j] != ed) begin mis_d++; if (first_bad < 0) first_bad = j; end
                    if (bs[j] != ((p == 0) ^ (p == corrupt)) || be[j] != (p == corrupt))
                        mis_f++;
                    j++;
                end
        end
        chk(mis_d == 0, "R4", {name, " forwarded data"}, mis_d, 0);
        chk(mis_f == 0, "R10", {name, " start flag and error pulse"}, mis_f, 0);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rx_enb_n && rx_addr == 5'h1F && !out_valid && !soc_err, "R1",
            "reset state", int'(rx_addr), 31);
    endtask

    task automatic t_single_pulse();   // R2 R3 R4 R5 R8
        do_reset(); corrupt = -1;
        exp_n = 1; exp_port[0] = 2; exp_cells[0] = 1;
        log_run(90, 4'b0010, 0, 4'b0000, -1, 4'b0000);
        analyze("single");
    endtask

    task automatic t_continue();       // R7 then R8
        do_reset(); corrupt = -1;
        exp_n = 1; exp_port[0] = 4; exp_cells[0] = 2;
        log_run(160, 4'b1000, 60, 4'b0000, -1, 4'b0000);
        analyze("continue");
    endtask

    task automatic t_alternate();      // R6 R9
        do_reset(); corrupt = -1;
        exp_n = 3; exp_port[0] = 1; exp_port[1] = 3; exp_port[2] = 1;
        exp_cells[0] = 1; exp_cells[1] = 1; exp_cells[2] = 1;
        log_run(240, 4'b0101, 150, 4'b0000, -1, 4'b0000);
        analyze("alternate");
    endtask

    task automatic t_all_four();       // R1 tie, R9 rotation
        do_reset(); corrupt = -1;
        exp_n = 4;
        for (int s = 0; s < 4; s++) begin exp_port[s] = s + 1; exp_cells[s] = 1; end
        log_run(300, 4'b1111, 200, 4'b0000, -1, 4'b0000);
        analyze("all-four");
    endtask

    task automatic t_after_three();    // R9 starts after last served
        do_reset(); corrupt = -1;
        exp_n = 3; exp_port[0] = 3; exp_port[1] = 4; exp_port[2] = 1;
        exp_cells[0] = 1; exp_cells[1] = 1; exp_cells[2] = 1;
        log_run(240, 4'b0100, 5, 4'b1011, 150, 4'b0000);
        analyze("after-three");
    endtask

    task automatic t_soc_fault(input int cp); // R10
        do_reset(); corrupt = cp;
        exp_n = 1; exp_port[0] = 1; exp_cells[0] = 1;
        log_run(90, 4'b0001, 0, 4'b0000, -1, 4'b0000);
        analyze(cp == 0 ? "soc-missing" : "soc-misplaced");
        corrupt = -1;
    endtask

    task automatic t_mid_reset();      // R1 during a cell
        do_reset(); corrupt = -1;
        cell_avail = 4'b0010;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(!rx_enb_n, "R3", "enable low mid-cell", int'(rx_enb_n), 0);
        cell_avail = 4'b0000;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rx_enb_n && rx_addr == 5'h1F, "R1", "reset mid-cell releases port",
            int'(rx_addr), 31);
        @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !soc_err, "R1", "reset clears byte strobe",
            int'(out_valid), 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset_state();
        t_single_pulse();
        t_continue();
        t_alternate();
        t_all_four();
        t_after_three();
        t_soc_fault(0);
        t_soc_fault(17);
        t_mid_reset();
        finish_run();
    end
endmodule